// File: doc/BRIEF.md
# Compare timer with downcounter view

This block is a physical-timer compare unit. It watches a free-running 64-bit system count supplied from outside. For each of two security banks it holds a 64-bit compare value and a small control register. When the count reaches the compare value of an enabled bank, that bank's level interrupt is raised, unless the bank masks it.

Software can program the deadline in two ways. It can write the absolute 64-bit compare value. It can also use a 32-bit signed "timer value" window. A write to that window places the deadline relative to the live count. A read returns the distance left to the deadline, so the window behaves like a 32-bit downcounter. That downcounter is only a computed view and holds no storage of its own.

An optional count offset, shared by both banks, can be subtracted from the count while an offset-mode input is high. The offset then shifts the writes, the reads and the comparison alike. A security input picks which bank a register access uses.

Top module: `phys_cmp_timer`

## Requirements
- R1: After reset, both compare values, both control registers and the offset are zero, and both interrupt outputs are low.
- R2: Address 0 reads and writes the full 64-bit compare value of the selected bank.
- R3: A write to address 1 sets the selected bank's compare value to the effective count plus bits 31:0 of the write data, sign-extended to 64 bits.
- R4: While the selected bank is enabled, a read of address 1 returns, in bits 31:0, the low 32 bits of (compare value minus effective count), with bits 63:32 zero. While the bank is disabled, the value read is unspecified.
- R5: A bank's condition is true only when its enable bit is 1 and the effective count, compared as an unsigned 64-bit number, is at least its compare value. The condition is re-evaluated every cycle.
- R6: The control register at address 2 has enable in bit 0, mask in bit 1 and a read-only status bit in bit 2 that mirrors the condition. Writes to bit 2 are ignored. A bank's interrupt is high exactly when its condition is true and its mask is 0.
- R7: With enable at 0, the condition and the interrupt stay low, but the count keeps running. After the bank is re-enabled, the downcounter view reflects all the time that elapsed.
- R8: While offsetMode is 1, the effective count is the count minus the offset. It is used for timer-value writes, timer-value reads and the condition. While offsetMode is 0, the effective count is the count itself.
- R9: secureSel=1 selects the secure bank and secureSel=0 the non-secure bank. An access to one bank leaves the other unchanged. irqOut[1] belongs to the secure bank and irqOut[0] to the non-secure bank.
- R10: Address 3 reads and writes the 64-bit offset, which is shared by both banks. Reads are combinational from the current address, bank, count and state.
- R11: A write takes effect at the rising clock edge where regWrEn is high and uses the countIn value present at that edge. It is visible on reads from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| countIn | input | 64 | Free-running system count |
| offsetMode | input | 1 | Subtract the offset register from the count |
| secureSel | input | 1 | Bank select: 1 secure, 0 non-secure |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 compare, 1 timer value, 2 control, 3 offset |
| regWrData | input | 64 | Write data (timer value uses bits 31:0) |
| regRdData | output | 64 | Combinational read data |
| irqOut | output | 2 | Level interrupts, bit 1 secure, bit 0 non-secure |

## Verification
The hardest case to reach is a deadline that wraps past the top of the 64-bit count. A small positive timer-value write made near the count's maximum gives a compare value below the current count, so the unsigned comparison fires at once. Reaching that case through ticking alone would take 2^64 cycles. The bench therefore jumps countIn directly to just under its maximum. It then writes a timer value in both offset modes and alternates banks in the same sequence. A random phase follows, with deadlines placed within a few dozen ticks of the live count, so that conditions rise, get masked and are disabled while being read through every address.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    ADDR_CMP  = 2'd0,
    ADDR_TVAL = 2'd1,
    ADDR_CTL  = 2'd2,
    ADDR_OFF  = 2'd3
  } reg_addr_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;

  typedef struct packed {
    logic      bank;
    logic      ldCmp;
    logic      ldTval;
    logic      ldCtl;
    logic      ldOff;
    reg_addr_e rdSel;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       secureSel,
  output strobe_t    strb
);
  reg_addr_e addrE;

  always_comb begin
    addrE       = reg_addr_e'(regAddr);
    strb        = '0;
    strb.bank   = secureSel;
    strb.rdSel  = addrE;
    strb.ldCmp  = regWrEn && (addrE == ADDR_CMP);
    strb.ldTval = regWrEn && (addrE == ADDR_TVAL);
    strb.ldCtl  = regWrEn && (addrE == ADDR_CTL);
    strb.ldOff  = regWrEn && (addrE == ADDR_OFF);
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] countIn,
  input  logic             offsetMode,
  output logic [CNT_W-1:0] rdData,
  output logic [NBANK-1:0] irqVec
);
  localparam int EXT_W = CNT_W - TV_W;

  logic [CNT_W-1:0] offReg;
  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] tvalExt;
  logic [CNT_W-1:0] cmpVal [NBANK];
  logic [NBANK-1:0] enVec, maskVec, condVec;

  assign effCount = offsetMode ? (countIn - offReg) : countIn;
  assign tvalExt  = {{EXT_W{wrData[TV_W-1]}}, wrData[TV_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           offReg <= '0;
    else if (strb.ldOff) offReg <= wrData;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0] cmpR;
    logic             enR, maskR;
    logic             hit;

    assign hit = (strb.bank == b[0]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpR  <= '0;
        enR   <= 1'b0;
        maskR <= 1'b0;
      end else if (hit) begin
        if (strb.ldCmp)  cmpR <= wrData;
        if (strb.ldTval) cmpR <= effCount + tvalExt;
        if (strb.ldCtl) begin
          enR   <= wrData[CTL_EN_BIT];
          maskR <= wrData[CTL_MASK_BIT];
        end
      end
    end

    assign cmpVal[b]  = cmpR;
    assign enVec[b]   = enR;
    assign maskVec[b] = maskR;
    assign condVec[b] = enR && (effCount >= cmpR);
    assign irqVec[b]  = condVec[b] && !maskR;
  end

  logic [CNT_W-1:0] selCmp;
  logic [TV_W-1:0]  tvalLow;

  assign selCmp  = cmpVal[strb.bank];
  assign tvalLow = selCmp[TV_W-1:0] - effCount[TV_W-1:0];

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      ADDR_CMP:  rdData = selCmp;
      ADDR_TVAL: if (enVec[strb.bank]) rdData[TV_W-1:0] = tvalLow;
      ADDR_CTL: begin
        rdData[CTL_EN_BIT]   = enVec[strb.bank];
        rdData[CTL_MASK_BIT] = maskVec[strb.bank];
        rdData[CTL_STAT_BIT] = condVec[strb.bank];
      end
      ADDR_OFF:  rdData = offReg;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/phys_cmp_timer.sv
module phys_cmp_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countIn,
  input  logic             offsetMode,
  input  logic             secureSel,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic [1:0]       irqOut
);
  strobe_t strb;

  tmr_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .secureSel(secureSel),
    .strb     (strb)
  );

  tmr_datapath #(.CNT_W(CNT_W), .TV_W(TV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (regWrData),
    .countIn   (countIn),
    .offsetMode(offsetMode),
    .rdData    (regRdData),
    .irqVec    (irqOut)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] countLo,
  input logic        offsetMode,
  input logic        secureSel,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [31:0] wrLo,
  input logic [31:0] rdLo,
  input logic [1:0]  irqOut
);
  // R3: timer-value write reads back as written minus elapsed ticks (or 0 if disabled)
  p_tval_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !offsetMode) |=>
      (!(regAddr == 2'd1 && secureSel == $past(secureSel) && !offsetMode)
       || rdLo == 32'd0
       || rdLo == $past(wrLo) - (countLo - $past(countLo))));

  // R5: disabled bank shows no status and no interrupt
  p_status_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2 && !rdLo[0]) |-> (!rdLo[2] && !irqOut[secureSel]));

  // R6: interrupt implies status set and mask clear
  p_irq_implies_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2 && irqOut[secureSel]) |-> (rdLo[2] && !rdLo[1]));

  // R7: clearing enable drops that bank's interrupt on the next cycle
  p_irq_off_when_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2 && !wrLo[0]) |=> !irqOut[$past(secureSel)]);

  // R11: control write is visible on the following cycle
  p_ctl_readback_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=>
      (!(regAddr == 2'd2 && secureSel == $past(secureSel))
       || rdLo[1:0] == $past(wrLo[1:0])));
endmodule

bind phys_cmp_timer tmr_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .countLo   (countIn[31:0]),
  .offsetMode(offsetMode),
  .secureSel (secureSel),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .wrLo      (regWrData[31:0]),
  .rdLo      (regRdData[31:0]),
  .irqOut    (irqOut)
);

// File: tb/phys_cmp_timer_bench.sv
module phys_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] countIn = '0;
  logic        offsetMode = 1'b0;
  logic        secureSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic [1:0]  irqOut;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference state
  logic [63:0] mCmp [2];
  bit          mEn [2];
  bit          mMask [2];
  logic [63:0] mOff;

  always #4 clk = ~clk; // 125 MHz

  phys_cmp_timer u_phys_cmp_timer (
    .clk(clk), .rstN(rstN), .countIn(countIn), .offsetMode(offsetMode),
    .secureSel(secureSel), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [63:0] effCnt();
    return offsetMode ? countIn - mOff : countIn;
  endfunction

  initial begin
    for (int b = 0; b < 2; b++) begin mCmp[b] = '0; mEn[b] = 0; mMask[b] = 0; end
    mOff = '0;
  end

  // reference model update (R11: uses inputs present at the edge)
  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin mCmp[b] = '0; mEn[b] = 0; mMask[b] = 0; end
      mOff = '0;
    end else if (regWrEn) begin
      int     sv;
      longint lv;
      int     bk;
      bk = secureSel ? 1 : 0;
      case (regAddr)
        2'd0: mCmp[bk] = regWrData;
        2'd1: begin
          sv = regWrData[31:0];
          lv = sv;
          mCmp[bk] = effCnt() + 64'(lv);
        end
        2'd2: begin mEn[bk] = regWrData[0]; mMask[bk] = regWrData[1]; end
        default: mOff = regWrData;
      endcase
    end
  end

  task automatic runChecks();
    logic [1:0]  expIrq;
    logic [63:0] expRd;
    logic [63:0] e;
    bit          doRd;
    int          bk;
    e = effCnt();
    for (int b = 0; b < 2; b++)
      expIrq[b] = mEn[b] && (e >= mCmp[b]) && !mMask[b];
    checks++;
    if (irqOut !== expIrq) begin
      errors++;
      $display("FAIL %s irqOut actual=%b expected=%b", curReq, irqOut, expIrq);
    end
    bk = secureSel ? 1 : 0;
    doRd = 1;
    expRd = '0;
    case (regAddr)
      2'd0: expRd = mCmp[bk];
      2'd1: begin
        if (!mEn[bk]) doRd = 0; // unspecified value, not checked (R4)
        else expRd = {32'd0, 32'(mCmp[bk] - e)};
      end
      2'd2: expRd = {61'd0, (mEn[bk] && e >= mCmp[bk]), mMask[bk], mEn[bk]};
      default: expRd = mOff;
    endcase
    if (doRd) begin
      checks++;
      if (regRdData !== expRd) begin
        errors++;
        $display("FAIL %s read addr=%0d bank=%0d actual=%h expected=%h",
                 curReq, regAddr, bk, regRdData, expRd);
      end
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      runChecks();
      countIn = countIn + 64'd1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d, logic sec);
    regWrEn = 1'b1; regAddr = a; regWrData = d; secureSel = sec;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic sec, int n = 1);
    regAddr = a; secureSel = sec;
    tick(n);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state of every register in both banks
    curReq = "R1";
    tick(3);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), 1'b0); rd(2'(a), 1'b1);
    end

    // R2 / R9: full-width compare per bank, banks independent
    curReq = "R2";
    wr(2'd0, 64'h1234_5678_9ABC_DEF0, 1'b0);
    rd(2'd0, 1'b0);
    curReq = "R9";
    wr(2'd0, 64'hFEDC_BA98_7654_3210, 1'b1);
    rd(2'd0, 1'b0); rd(2'd0, 1'b1);

    // R10: shared offset register
    curReq = "R10";
    wr(2'd3, 64'hA5A5_0000_0000_5A5A, 1'b1);
    rd(2'd3, 1'b0); rd(2'd3, 1'b1);
    wr(2'd3, 64'd0, 1'b0);

    // R3 / R4: positive timer value counts down, R5/R6 condition and interrupt
    curReq = "R3";
    countIn = 64'd1000;
    wr(2'd1, 64'd10, 1'b0);
    curReq = "R11";
    wr(2'd2, 64'd1, 1'b0);
    curReq = "R4";
    rd(2'd1, 1'b0, 12);
    curReq = "R5";
    rd(2'd2, 1'b0, 3);
    // R6: mask hides interrupt, status bit write ignored
    curReq = "R6";
    wr(2'd2, 64'd7, 1'b0);
    rd(2'd2, 1'b0, 2);
    wr(2'd2, 64'd5, 1'b0);
    rd(2'd2, 1'b0, 2);

    // R3: negative timer value -> deadline already passed
    curReq = "R3";
    wr(2'd1, 64'h0000_0000_FFFF_FFFB, 1'b1);
    wr(2'd2, 64'd1, 1'b1);
    rd(2'd1, 1'b1, 2); rd(2'd2, 1'b1, 2);

    // R7: disable keeps the interrupt low while count keeps running
    curReq = "R7";
    wr(2'd1, 64'd20, 1'b0);
    wr(2'd2, 64'd0, 1'b0);
    rd(2'd2, 1'b0, 30);
    wr(2'd2, 64'd1, 1'b0);
    rd(2'd1, 1'b0, 3); rd(2'd2, 1'b0, 2);

    // R8: offset mode affects write, read and condition
    curReq = "R8";
    wr(2'd3, 64'h100, 1'b0);
    offsetMode = 1'b1;
    wr(2'd1, 64'd50, 1'b0);
    rd(2'd1, 1'b0, 5);
    offsetMode = 1'b0;
    rd(2'd1, 1'b0, 3); rd(2'd2, 1'b0, 2);
    offsetMode = 1'b1;
    wr(2'd0, countIn - 64'h100 + 64'd4, 1'b1);
    rd(2'd2, 1'b1, 8);

    // R5: wraparound of the 64-bit deadline, unsigned compare
    curReq = "R5";
    offsetMode = 1'b0;
    countIn = 64'hFFFF_FFFF_FFFF_FFF0;
    wr(2'd1, 64'd100, 1'b0);
    rd(2'd2, 1'b0, 3); rd(2'd1, 1'b0, 20);
    offsetMode = 1'b1;
    wr(2'd1, 64'd6, 1'b1);
    rd(2'd2, 1'b1, 10);

    // random phase
    curReq = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r, sv;
      r = int'($urandom % 8);
      if ($urandom % 16 == 0) offsetMode = ~offsetMode;
      if ($urandom % 200 == 0) countIn = {$urandom, $urandom};
      if (r == 0) begin
        sv = int'($urandom % 64) - 20;
        wr(2'd1, {32'd0, 32'(sv)}, 1'($urandom));
      end else if (r == 1) wr(2'd2, 64'($urandom % 8), 1'($urandom));
      else if (r == 2) wr(2'd0, countIn + 64'($urandom % 40), 1'($urandom));
      else if (r == 3) wr(2'd3, 64'($urandom % 32), 1'($urandom));
      else rd(2'($urandom), 1'($urandom));
    end

    finishRun();
  end
endmodule